// File: doc/BRIEF.md
# Bit-Serial Shift and Rotate Unit with Extend Flag

This unit performs the four shift and rotate operations of a classic 16/32-bit processor: arithmetic shift, logical shift, rotate through the extend flag, and plain rotate. Each operation runs left or right on a byte, word or long operand. Bits above the selected size pass through to the result unchanged. The shift count comes from one of two places. The first is a 3-bit field from the instruction word. The second is the low bits of a data register. A separate memory form shifts a single word by one position.

The unit is bit-serial. After an accepted start strobe it moves the operand one position per clock, so its latency follows the count the way the real execution cost does. It also reports that cost as a cycle figure. When the last step is done it presents the result and the N, Z, V, C and X flags, and it pulses done for one clock. A start strobe that arrives while the unit is busy has no effect.

Top module: `shift_rotate_unit`

## Requirements
- R1: `kind` selects the operation: 00 arithmetic shift, 01 logical shift, 10 rotate through X, 11 plain rotate. `left`=1 shifts toward the most significant bit and 0 shifts toward bit 0. An arithmetic right shift refills the top with the sign bit. A logical shift fills with 0. A plain rotate feeds the bit that leaves back in at the other end. Rotate through X feeds X in and moves the bit that leaves into X.
- R2: When `cnt_from_reg`=0 the count is `cnt_imm`, and the value 000 means a count of 8.
- R3: When `cnt_from_reg`=1 the count is `cnt_reg` modulo 64, which is its low six bits.
- R4: `cycles` is 6 for byte or word and 8 for long, plus 2 for each unit of the count taken before any ring reduction. The memory form always reports 8.
- R5: For arithmetic and logical shifts, C and X both receive the last bit shifted out. With a count of zero, C is 0 and X keeps `x_in`.
- R6: For an arithmetic left shift, V is 1 if the most significant bit of the sized field changes at any step. Every other operation gives V=0.
- R7: Rotate through X treats the sized operand plus X as a ring of width+1 bits: 9, 17 or 33. A register count is reduced modulo width+1 before shifting.
- R8: Rotate through X with an effective count of zero leaves the operand and X unchanged and sets C equal to X.
- R9: A plain rotate leaves X at `x_in` and gives V=0. C is the last bit rotated out, or 0 when the count is zero.
- R10: N is the top bit of the sized result and Z is 1 when the sized result is zero. Result bits above the selected size equal the operand's bits.
- R11: When `mem_form`=1 the operation is a word-sized shift by exactly one position. `size`, `cnt_from_reg`, `cnt_imm` and `cnt_reg` are ignored.
- R12: `done` is high for exactly one clock. It rises on the edge that follows the start-sampling edge by (effective step count + 1) clocks. A start strobe while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| kind | input | 2 | Operation select |
| left | input | 1 | 1 = shift toward MSB |
| size | input | 2 | 00 byte, 01 word, 10 long |
| mem_form | input | 1 | 1 = word, one position |
| cnt_from_reg | input | 1 | 1 = count from `cnt_reg` |
| cnt_imm | input | 3 | Immediate count (000 = 8) |
| cnt_reg | input | 32 | Register value supplying the count |
| operand | input | 32 | Value to shift |
| x_in | input | 1 | Incoming extend flag |
| result | output | 32 | Shifted value |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |
| flag_x | output | 1 | Extend |
| cycles | output | 8 | Modelled execution cost |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The embedded properties assume that `size` never carries the unused code 11 when a start is accepted. They also assume a single agent drives the start and operand inputs. The stimulus draws `size` only from 0 to 2. In memory form it leaves `size` and the count inputs deliberately at unrelated values, because those inputs must then be ignored. Some operations present a second start pulse while the unit is busy, using a different operand, so that the scoreboard can show that the first result is unaffected.

// File: rtl/sru_pkg.sv
// Shared types and helpers for the shift/rotate unit.
// Assumes the data path is 32 bits wide and sizes are byte/word/long.
package sru_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;
    localparam int CYC_W  = 8;
    localparam int BASE_SHORT = 6;
    localparam int BASE_LONG  = 8;

    typedef enum logic [1:0] {
        SK_ARITH = 2'b00,
        SK_LOGIC = 2'b01,
        SK_ROTX  = 2'b10,
        SK_ROT   = 2'b11
    } sru_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } sru_size_e;

    // Mask of the bits that belong to the sized field.
    function automatic logic [DATA_W-1:0] sz_mask(input sru_size_e s);
        case (s)
            SZ_BYTE: return DATA_W'(32'h0000_00FF);
            SZ_WORD: return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

    // Index of the top bit of the sized field.
    function automatic logic [4:0] sz_top(input sru_size_e s);
        case (s)
            SZ_BYTE: return 5'd7;
            SZ_WORD: return 5'd15;
            default: return 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/sru_count.sv
// Count decode: picks the count source, applies the immediate 000 = 8
// rule, reduces register counts for the extend ring, and computes cost.
// Assumes size is never 2'b11 when used.
module sru_count
    import sru_pkg::*;
(
    input  sru_kind_e          kind,
    input  sru_size_e          size,
    input  logic               mem_form,
    input  logic               from_reg,
    input  logic [2:0]         imm,
    input  logic [CNT_W-1:0]   reg_lo,
    output sru_size_e          eff_size,
    output logic [CNT_W-1:0]   steps,
    output logic [CYC_W-1:0]   cyc
);
    logic [CNT_W-1:0] raw;
    logic [CNT_W-1:0] ring;

    // Select raw count and effective size.
    always_comb begin
        if (mem_form) begin
            raw      = CNT_W'(1);
            eff_size = SZ_WORD;
        end else begin
            raw      = from_reg ? reg_lo : ((imm == 3'd0) ? CNT_W'(8) : CNT_W'(imm));
            eff_size = size;
        end
    end

    // Reduce a register count modulo the ring width (width + 1).
    always_comb begin
        case (eff_size)
            SZ_BYTE: ring = raw % CNT_W'(9);
            SZ_WORD: ring = raw % CNT_W'(17);
            default: ring = raw % CNT_W'(33);
        endcase
        steps = (kind == SK_ROTX && from_reg && !mem_form) ? ring : raw;
    end

    // Cost figure: base by size plus two per raw count unit.
    always_comb begin
        cyc = ((eff_size == SZ_LONG) ? CYC_W'(BASE_LONG) : CYC_W'(BASE_SHORT))
              + (CYC_W'(raw) << 1);
    end
endmodule

// File: rtl/sru_step.sv
// One single-position shift/rotate of the sized field; bits above the
// field pass through. Also reports the bit that leaves and a sign change.
module sru_step
    import sru_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  sru_size_e         size,
    input  sru_kind_e         kind,
    input  logic              left,
    input  logic              xin,
    output logic [DATA_W-1:0] nxt,
    output logic              bit_out,
    output logic              sign_flip
);
    logic [DATA_W-1:0] mask, field, nf;
    logic [4:0]        top;
    logic              msb, lsb, fill_l, fill_r;

    // Single-step datapath.
    always_comb begin
        mask  = sz_mask(size);
        top   = sz_top(size);
        field = val & mask;
        msb   = val[top];
        lsb   = val[0];
        case (kind)
            SK_ROTX: begin fill_l = xin; fill_r = xin; end
            SK_ROT:  begin fill_l = msb; fill_r = lsb; end
            SK_ARITH: begin fill_l = 1'b0; fill_r = msb; end
            default: begin fill_l = 1'b0; fill_r = 1'b0; end
        endcase
        if (left) nf = ((field << 1) | DATA_W'(fill_l)) & mask;
        else      nf = (field >> 1) | (DATA_W'(fill_r) << top);
        nxt       = (val & ~mask) | nf;
        bit_out   = left ? msb : lsb;
        sign_flip = nxt[top] ^ msb;
    end
endmodule

// File: rtl/sru_flags.sv
// N and Z from the sized portion of a value.
module sru_flags
    import sru_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  sru_size_e         size,
    output logic              neg,
    output logic              zero
);
    // Sized sign and zero detect.
    always_comb begin
        neg  = res[sz_top(size)];
        zero = ((res & sz_mask(size)) == '0);
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Bit-serial shift/rotate unit. Latches an operation on an idle start,
// shifts one position per clock, then publishes result and flags with a
// one-clock done pulse. Assumes size != 2'b11 on accepted starts.
module shift_rotate_unit
    import sru_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  kind,
    input  logic        left,
    input  logic [1:0]  size,
    input  logic        mem_form,
    input  logic        cnt_from_reg,
    input  logic [2:0]  cnt_imm,
    input  logic [31:0] cnt_reg,
    input  logic [31:0] operand,
    input  logic        x_in,
    output logic [31:0] result,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c,
    output logic        flag_x,
    output logic [7:0]  cycles,
    output logic        busy,
    output logic        done
);
    sru_size_e         eff_size, size_q;
    sru_kind_e         kind_q;
    logic              left_q;
    logic [CNT_W-1:0]  steps, rem, steps_q;
    logic [CYC_W-1:0]  cyc, cyc_q;
    logic [DATA_W-1:0] work, nxt;
    logic              xr, cr, vr, bit_out, sign_flip, neg, zero;

    sru_count u_count (
        .kind(sru_kind_e'(kind)), .size(sru_size_e'(size)), .mem_form(mem_form),
        .from_reg(cnt_from_reg), .imm(cnt_imm), .reg_lo(cnt_reg[CNT_W-1:0]),
        .eff_size(eff_size), .steps(steps), .cyc(cyc)
    );

    sru_step u_step (
        .val(work), .size(size_q), .kind(kind_q), .left(left_q), .xin(xr),
        .nxt(nxt), .bit_out(bit_out), .sign_flip(sign_flip)
    );

    sru_flags u_flags (.res(work), .size(size_q), .neg(neg), .zero(zero));

    // Sequencer: load on idle start, step while count remains, then publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; done <= 1'b0; rem <= '0; steps_q <= '0; work <= '0;
            xr <= 1'b0; cr <= 1'b0; vr <= 1'b0; kind_q <= SK_ARITH;
            size_q <= SZ_BYTE; left_q <= 1'b0; cyc_q <= '0;
            result <= '0; flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0;
            flag_c <= 1'b0; flag_x <= 1'b0; cycles <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    work    <= operand;
                    rem     <= steps;
                    steps_q <= steps;
                    kind_q  <= sru_kind_e'(kind);
                    size_q  <= eff_size;
                    left_q  <= mem_form ? left : left;
                    xr      <= x_in;
                    cr      <= (sru_kind_e'(kind) == SK_ROTX) ? x_in : 1'b0;
                    vr      <= 1'b0;
                    cyc_q   <= cyc;
                end
            end else if (rem != '0) begin
                work <= nxt;
                rem  <= rem - CNT_W'(1);
                cr   <= bit_out;
                if (kind_q != SK_ROT) xr <= bit_out;
                if (kind_q == SK_ARITH && left_q && sign_flip) vr <= 1'b1;
            end else begin
                busy   <= 1'b0;
                done   <= 1'b1;
                result <= work;
                flag_n <= neg;
                flag_z <= zero;
                flag_v <= vr;
                flag_c <= cr;
                flag_x <= xr;
                cycles <= cyc_q;
            end
        end
    end

    // Input assumption: no unused size code on an accepted start.
    p_size_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mem_form) |-> (size != 2'b11));
    // R12: done is a single-clock pulse, and only when idle.
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6: only arithmetic left shift may report overflow.
    p_v_only_asl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(kind_q == SK_ARITH && left_q)) |-> !flag_v);
    // R9: plain rotate never alters the extend flag while stepping.
    p_rot_keeps_x_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == SK_ROT) |=> (xr == $past(xr)));
    // R10: stepping a byte leaves the upper bits alone.
    p_upper_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && size_q == SZ_BYTE) |=> (work[31:8] == $past(work[31:8])));
    // R8: zero-step extend rotate reports C equal to X.
    p_rotx_zero_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == SK_ROTX && steps_q == '0) |-> (flag_c == flag_x));
    // R4: cost figure is always even and at least 6.
    p_cycles_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cycles[0] && cycles >= 8'd6));
endmodule

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic        left = 1'b0;
    logic [1:0]  size = 2'd0;
    logic        mem_form = 1'b0;
    logic        cnt_from_reg = 1'b0;
    logic [2:0]  cnt_imm = 3'd0;
    logic [31:0] cnt_reg = 32'd0;
    logic [31:0] operand = 32'd0;
    logic        x_in = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, flag_x, busy, done;
    logic [7:0]  cycles;

    shift_rotate_unit i_shift_rotate_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .left(left),
        .size(size), .mem_form(mem_form), .cnt_from_reg(cnt_from_reg),
        .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .operand(operand), .x_in(x_in),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .flag_x(flag_x), .cycles(cycles), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    typedef struct {
        string       tag;
        logic [31:0] res;
        logic        n, z, v, c, x;
        int          cyc;
        int          lat;
        int          t0;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   tick     = 0;

    always @(posedge clk) tick <= tick + 1;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference behaviour written from the requirements.
    function automatic exp_t model(input string tag, input int k, input bit lf, input int sz,
                                   input bit mem, input bit fr, input int imm,
                                   input logic [31:0] rg, input logic [31:0] op, input bit xi);
        exp_t e;
        int w, n, st, top;
        logic [31:0] mask, f;
        bit c, xx, v, msb, lsb, fb;
        w = mem ? 16 : (sz == 0 ? 8 : (sz == 1 ? 16 : 32));
        n = mem ? 1 : (fr ? int'(rg[5:0]) : (imm == 0 ? 8 : imm));
        e.cyc = (w == 32 ? 8 : 6) + 2 * n;
        st = (k == 2 && fr && !mem) ? n % (w + 1) : n;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        top = w - 1;
        f = op & mask;
        c = (k == 2) ? xi : 1'b0;
        xx = xi; v = 1'b0;
        for (int i = 0; i < st; i++) begin
            msb = f[top]; lsb = f[0];
            if (lf) begin
                fb = (k == 2) ? xx : ((k == 3) ? msb : 1'b0);
                f = ((f << 1) | 32'(fb)) & mask;
                c = msb;
            end else begin
                fb = (k == 0) ? msb : ((k == 2) ? xx : ((k == 3) ? lsb : 1'b0));
                f = (f >> 1) | (32'(fb) << top);
                c = lsb;
            end
            if (k != 3) xx = c;
            if (k == 0 && lf && (f[top] != msb)) v = 1'b1;
        end
        e.tag = tag;
        e.res = (op & ~mask) | f;
        e.n = f[top]; e.z = (f == 32'd0); e.v = v; e.c = c; e.x = xx;
        e.lat = st + 2;
        e.t0 = 0;
        return e;
    endfunction

    // Driver: push the expectation, pulse start, optionally poke while busy.
    task automatic apply(input string tag, input int k, input bit lf, input int sz,
                         input bit mem, input bit fr, input int imm, input logic [31:0] rg,
                         input logic [31:0] op, input bit xi, input bit poke);
        exp_t e;
        int guard;
        e = model(tag, k, lf, sz, mem, fr, imm, rg, op, xi);
        @(negedge clk);
        kind = 2'(k); left = lf; size = 2'(sz); mem_form = mem; cnt_from_reg = fr;
        cnt_imm = 3'(imm); cnt_reg = rg; operand = op; x_in = xi; start = 1'b1;
        e.t0 = tick;
        q.push_back(e);
        @(negedge clk);
        if (poke) begin
            operand = ~op; kind = 2'(k + 1); x_in = ~xi; cnt_imm = 3'd3;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (q.size() != 0 && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        if (q.size() != 0) begin
            check(tag, "timeout", 1, 0);
            q.delete();
        end
    endtask

    // Monitor: pop and compare on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check("R12", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "result", result, e.res);
                check(e.tag, "N", flag_n, e.n);
                check(e.tag, "Z", flag_z, e.z);
                check(e.tag, "V", flag_v, e.v);
                check(e.tag, "C", flag_c, e.c);
                check(e.tag, "X", flag_x, e.x);
                check(e.tag, "cycles", cycles, e.cyc);
                check({e.tag, "/R12"}, "latency", tick - e.t0, e.lat);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 reset", "done", done, 0);
        check("R12 reset", "busy", busy, 0);
        check("R10 reset", "result", result, 0);
        // R1: each kind and direction
        apply("R1 asr", 0, 0, 0, 0, 0, 1, 0, 32'h0000_0080, 0, 0);
        apply("R1 lsr", 1, 0, 0, 0, 0, 1, 0, 32'h0000_0081, 0, 0);
        apply("R1 roxr", 2, 0, 1, 0, 0, 2, 0, 32'h0000_8001, 1, 0);
        apply("R1 rol", 3, 1, 2, 0, 0, 4, 0, 32'hF000_0001, 0, 0);
        apply("R1 lsl", 1, 1, 1, 0, 0, 3, 0, 32'h0000_C003, 1, 0);
        // R2: immediate 000 means 8
        apply("R2 imm0", 1, 1, 2, 0, 0, 0, 0, 32'h0000_0001, 0, 0);
        // R3: register count modulo 64
        apply("R3 mod64", 1, 1, 2, 0, 1, 0, 32'h0000_0041, 32'h0000_0003, 0, 0);
        apply("R3 big", 0, 0, 2, 0, 1, 0, 32'hFFFF_FFE0, 32'h8000_0000, 0, 0);
        // R4: cost on long with register count
        apply("R4 cost", 1, 0, 2, 0, 1, 0, 32'd63, 32'hFFFF_FFFF, 0, 0);
        // R5: zero count shift keeps X, clears C
        apply("R5 zero", 1, 1, 0, 0, 1, 0, 32'd0, 32'h0000_00FF, 1, 0);
        apply("R5 lastout", 0, 0, 1, 0, 1, 0, 32'd20, 32'h0000_8000, 0, 0);
        // R6: overflow on any sign change
        apply("R6 v1", 0, 1, 0, 0, 0, 1, 0, 32'h0000_0040, 0, 0);
        apply("R6 v2", 0, 1, 0, 0, 0, 3, 0, 32'h0000_00E0, 0, 0);
        apply("R6 v3", 0, 1, 0, 0, 0, 2, 0, 32'h0000_0020, 0, 0);
        apply("R6 lslnov", 1, 1, 0, 0, 0, 1, 0, 32'h0000_0040, 0, 0);
        // R7: ring of width+1
        apply("R7 ring9", 2, 1, 0, 0, 1, 0, 32'd9, 32'h0000_00A5, 1, 0);
        apply("R7 ring10", 2, 1, 0, 0, 1, 0, 32'd10, 32'h0000_00A5, 1, 0);
        apply("R7 ring33", 2, 0, 2, 0, 1, 0, 32'd34, 32'h1234_5679, 0, 0);
        // R8: extend rotate zero count
        apply("R8 zero", 2, 0, 1, 0, 1, 0, 32'd17, 32'h0000_1234, 1, 0);
        // R9: plain rotate
        apply("R9 zero", 3, 0, 0, 0, 1, 0, 32'd0, 32'h0000_0081, 1, 0);
        apply("R9 keepx", 3, 1, 2, 0, 0, 1, 0, 32'h8000_0000, 0, 0);
        // R10: upper bits preserved, N/Z sized
        apply("R10 upper", 1, 1, 0, 0, 0, 1, 0, 32'hDEAD_BE80, 0, 0);
        apply("R10 neg", 1, 1, 1, 0, 0, 1, 0, 32'hFFFF_4000, 0, 0);
        // R11: memory form ignores size and count
        apply("R11 mem", 0, 1, 2, 1, 1, 5, 32'd7, 32'hABCD_C001, 0, 0);
        apply("R11 memr", 1, 0, 0, 1, 0, 0, 0, 32'h1234_8003, 0, 0);
        // R12: start ignored while busy
        apply("R12 poke", 1, 1, 1, 0, 0, 5, 0, 32'h0000_00F1, 0, 1);
        apply("R12 poke0", 3, 0, 0, 0, 1, 0, 32'd0, 32'h0000_0055, 1, 1);
        // Mixed patterns across all requirements (R1 R5 R6 R7 R9 R10)
        for (int i = 0; i < 300; i++) begin
            apply("R1 mix", int'($urandom % 4), 1'($urandom), int'($urandom % 3),
                  ($urandom % 8) == 0, 1'($urandom), int'($urandom % 8),
                  $urandom, $urandom, 1'($urandom), ($urandom % 16) == 0);
        end
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule